// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Vector Generator

This block handles the acknowledge cycle of two chained 8-input interrupt controllers. The secondary controller reports into input 2 of the primary one. Each controller's prioritisation logic gives this block its current winning input and a flag saying whether that winner is valid. When the processor strobes an acknowledge, the block decides which controller or controllers must see an acknowledge. It then forms the 8-bit interrupt vector from the programmed vector bases and returns it one cycle later.

If a controller has no valid winner at acknowledge time, the block returns a fallback vector equal to that controller's base plus 7. The block also drives the request line from the secondary controller into the primary one. While the secondary controller holds a valid winner, that line alternates high and low, so an edge-sensitive input on the primary controller keeps seeing fresh rising edges. After an accepted acknowledge, the block ignores any acknowledge request in the very next cycle. That gap lets both controllers take in their acknowledge before the next decision is made.

Top module: `cascade_ack_vec`

## Requirements
- R1: After reset, priAck, secAck, vecValid and cascadeReq are all 0.
- R2: The vector's upper five bits come from bits 7:3 of the selected base input. Bits 2:0 of the base are discarded. The vector's lower three bits carry the chosen input number, or 7 for a fallback.
- R3: On an accepted acknowledge where priValid=1 and priWin!=2, priAck pulses with priAckNum=priWin. secAck stays 0, and the vector equals (priBase AND 0xF8)+priWin.
- R4: On an accepted acknowledge where priValid=1, priWin=2 and secValid=1, priAck pulses with priAckNum=2 and secAck pulses with secAckNum=secWin. The vector equals (secBase AND 0xF8)+secWin.
- R5: On an accepted acknowledge where priValid=1, priWin=2 and secValid=0, priAck pulses with priAckNum=2 and secAck stays 0. The vector equals (secBase AND 0xF8)+7.
- R6: On an accepted acknowledge where priValid=0, neither acknowledge strobe is raised, and the vector equals (priBase AND 0xF8)+7.
- R7: An acknowledge request sampled at clock edge N is accepted when no acknowledge was accepted at edge N-1. For an accepted request, vecValid, the vector and the acknowledge strobes appear after edge N, and the strobes and vecValid last exactly one cycle.
- R8: An acknowledge request at the edge directly after an accepted one is ignored. It produces no vecValid, no priAck and no secAck.
- R9: cascadeReq is 1 after an edge exactly when secValid was 1 at that edge and cascadeReq was 0 before it. While secValid stays high, this gives a 1,0,1,0 pattern.
- R10: Without an accepted acknowledge request, priAck, secAck and vecValid stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ackReq | input | 1 | Processor acknowledge request |
| priValid | input | 1 | Primary controller has a valid winner |
| priWin | input | 3 | Primary controller winning input |
| secValid | input | 1 | Secondary controller has a valid winner |
| secWin | input | 3 | Secondary controller winning input |
| priBase | input | 8 | Primary programmed vector base |
| secBase | input | 8 | Secondary programmed vector base |
| priAck | output | 1 | Acknowledge strobe to the primary controller |
| priAckNum | output | 3 | Input acknowledged on the primary controller |
| secAck | output | 1 | Acknowledge strobe to the secondary controller |
| secAckNum | output | 3 | Input acknowledged on the secondary controller |
| vecValid | output | 1 | Vector output is valid this cycle |
| vector | output | 8 | Interrupt vector |
| cascadeReq | output | 1 | Secondary-to-primary request line |

## Verification
The assertions assume that winner and valid inputs are stable at the edge where an acknowledge request is sampled. They also assume that the base inputs are whatever the processor programmed, with no alignment guaranteed. The stimulus changes every input only at the falling edge and deliberately uses base values with nonzero low bits, which exercises the masking. It sweeps every combination of both valid flags and both winners under several base pairs, leaving an idle cycle between acknowledges. Separate phases hold the request for two cycles and hold the secondary valid flag steady, to cover the ignored request and the cascade pulse train.

// File: rtl/cav_pkg.sv
package cav_pkg;
  typedef struct packed {
    logic load;
    logic ackPri;
    logic ackSec;
    logic useSecBase;
    logic spurious;
  } cav_strobe_t;
endpackage

// File: rtl/cav_ctrl.sv
module cav_ctrl
  import cav_pkg::*;
#(
  parameter int IN_W     = 3,
  parameter int CASC_IDX = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ackReq,
  input  logic            priValid,
  input  logic [IN_W-1:0] priWin,
  input  logic            secValid,
  output cav_strobe_t     strb,
  output logic            cascadeReq
);
  localparam logic [IN_W-1:0] CASC = IN_W'(CASC_IDX);

  logic busyQ;
  logic accept;
  logic viaCascade;

  assign accept     = ackReq & ~busyQ;
  assign viaCascade = priValid & (priWin == CASC);

  always_comb begin
    strb            = '0;
    strb.load       = accept;
    strb.ackPri     = accept & priValid;
    strb.ackSec     = accept & viaCascade & secValid;
    strb.useSecBase = viaCascade;
    strb.spurious   = ~priValid | (viaCascade & ~secValid);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ      <= 1'b0;
      cascadeReq <= 1'b0;
    end else begin
      busyQ      <= accept;
      cascadeReq <= secValid & ~cascadeReq;
    end
  end
endmodule

// File: rtl/cav_dpath.sv
module cav_dpath
  import cav_pkg::*;
#(
  parameter int IN_W  = 3,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cav_strobe_t      strb,
  input  logic [IN_W-1:0]  priWin,
  input  logic [IN_W-1:0]  secWin,
  input  logic [VEC_W-1:0] priBase,
  input  logic [VEC_W-1:0] secBase,
  output logic             priAck,
  output logic [IN_W-1:0]  priAckNum,
  output logic             secAck,
  output logic [IN_W-1:0]  secAckNum,
  output logic             vecValid,
  output logic [VEC_W-1:0] vector
);
  localparam logic [VEC_W-1:0] BASE_MASK = ~VEC_W'((1 << IN_W) - 1);
  localparam logic [IN_W-1:0]  SPUR_IDX  = '1;

  logic [IN_W-1:0]  idxSel;
  logic [VEC_W-1:0] baseSel;
  logic [VEC_W-1:0] vecNext;

  always_comb begin
    baseSel = strb.useSecBase ? secBase : priBase;
    if (strb.spurious)        idxSel = SPUR_IDX;
    else if (strb.useSecBase) idxSel = secWin;
    else                      idxSel = priWin;
    vecNext = (baseSel & BASE_MASK) | VEC_W'(idxSel);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      priAck    <= 1'b0;
      secAck    <= 1'b0;
      vecValid  <= 1'b0;
      priAckNum <= '0;
      secAckNum <= '0;
      vector    <= '0;
    end else begin
      priAck   <= strb.ackPri;
      secAck   <= strb.ackSec;
      vecValid <= strb.load;
      if (strb.ackPri) priAckNum <= priWin;
      if (strb.ackSec) secAckNum <= secWin;
      if (strb.load)   vector    <= vecNext;
    end
  end
endmodule

// File: rtl/cascade_ack_vec.sv
module cascade_ack_vec
  import cav_pkg::*;
#(
  parameter int IN_W     = 3,
  parameter int VEC_W    = 8,
  parameter int CASC_IDX = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ackReq,
  input  logic             priValid,
  input  logic [IN_W-1:0]  priWin,
  input  logic             secValid,
  input  logic [IN_W-1:0]  secWin,
  input  logic [VEC_W-1:0] priBase,
  input  logic [VEC_W-1:0] secBase,
  output logic             priAck,
  output logic [IN_W-1:0]  priAckNum,
  output logic             secAck,
  output logic [IN_W-1:0]  secAckNum,
  output logic             vecValid,
  output logic [VEC_W-1:0] vector,
  output logic             cascadeReq
);
  cav_strobe_t strb;

  cav_ctrl #(.IN_W(IN_W), .CASC_IDX(CASC_IDX)) ctrl_i (
    .clk(clk), .rstN(rstN), .ackReq(ackReq), .priValid(priValid),
    .priWin(priWin), .secValid(secValid), .strb(strb), .cascadeReq(cascadeReq)
  );

  cav_dpath #(.IN_W(IN_W), .VEC_W(VEC_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .priWin(priWin), .secWin(secWin),
    .priBase(priBase), .secBase(secBase), .priAck(priAck), .priAckNum(priAckNum),
    .secAck(secAck), .secAckNum(secAckNum), .vecValid(vecValid), .vector(vector)
  );
endmodule

// File: rtl/cav_checker.sv
module cav_checker #(
  parameter int IN_W     = 3,
  parameter int VEC_W    = 8,
  parameter int CASC_IDX = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             ackReq,
  input logic             secValid,
  input logic             priAck,
  input logic [IN_W-1:0]  priAckNum,
  input logic             secAck,
  input logic [IN_W-1:0]  secAckNum,
  input logic             vecValid,
  input logic [VEC_W-1:0] vector,
  input logic             cascadeReq
);
  localparam logic [IN_W-1:0] CASC = IN_W'(CASC_IDX);

  p_strobes_need_vec_r10: assert property (@(posedge clk) disable iff (!rstN)
    (priAck | secAck) |-> vecValid);
  p_vec_from_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(ackReq));
  p_vec_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid);
  p_sec_via_casc_r4: assert property (@(posedge clk) disable iff (!rstN)
    secAck |-> (priAck && priAckNum == CASC));
  p_sec_index_r2: assert property (@(posedge clk) disable iff (!rstN)
    secAck |-> (vector[IN_W-1:0] == secAckNum));
  p_spur_index_r6: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && !priAck) |-> (vector[IN_W-1:0] == '1));
  p_casc_alt_r9: assert property (@(posedge clk) disable iff (!rstN)
    cascadeReq |=> !cascadeReq);
  p_casc_src_r9: assert property (@(posedge clk) disable iff (!rstN)
    cascadeReq |-> $past(secValid));
endmodule

bind cascade_ack_vec cav_checker #(.IN_W(IN_W), .VEC_W(VEC_W), .CASC_IDX(CASC_IDX)) chk_i (
  .clk(clk), .rstN(rstN), .ackReq(ackReq), .secValid(secValid), .priAck(priAck),
  .priAckNum(priAckNum), .secAck(secAck), .secAckNum(secAckNum),
  .vecValid(vecValid), .vector(vector), .cascadeReq(cascadeReq)
);

// File: tb/cascade_ack_vec_tb.sv
module cascade_ack_vec_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ackReq = 1'b0;
  logic       priValid = 1'b0;
  logic [2:0] priWin = '0;
  logic       secValid = 1'b0;
  logic [2:0] secWin = '0;
  logic [7:0] priBase = '0;
  logic [7:0] secBase = '0;
  logic       priAck, secAck, vecValid, cascadeReq;
  logic [2:0] priAckNum, secAckNum;
  logic [7:0] vector;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_ack_vec dut_i (
    .clk(clk), .rstN(rstN), .ackReq(ackReq), .priValid(priValid), .priWin(priWin),
    .secValid(secValid), .secWin(secWin), .priBase(priBase), .secBase(secBase),
    .priAck(priAck), .priAckNum(priAckNum), .secAck(secAck), .secAckNum(secAckNum),
    .vecValid(vecValid), .vector(vector), .cascadeReq(cascadeReq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doAck(input logic pv, input logic [2:0] pw, input logic sv, input logic [2:0] sw);
    int expVec, expPa, expSa;
    string tag;
    priValid = pv; priWin = pw; secValid = sv; secWin = sw; ackReq = 1'b1;
    @(posedge clk); @(negedge clk);
    ackReq = 1'b0;
    if (!pv) begin
      tag = "R6"; expVec = (priBase & 8'hF8) + 7; expPa = 0; expSa = 0;
    end else if (pw != 3'd2) begin
      tag = "R3"; expVec = (priBase & 8'hF8) + pw; expPa = 1; expSa = 0;
    end else if (sv) begin
      tag = "R4"; expVec = (secBase & 8'hF8) + sw; expPa = 1; expSa = 1;
    end else begin
      tag = "R5"; expVec = (secBase & 8'hF8) + 7; expPa = 1; expSa = 0;
    end
    check({tag, " R2 vector"}, vector, expVec);
    check({tag, " R7 vecValid"}, vecValid, 1);
    check({tag, " priAck"}, priAck, expPa);
    check({tag, " secAck"}, secAck, expSa);
    if (expPa == 1) check({tag, " priAckNum"}, priAckNum, pw);
    if (expSa == 1) check({tag, " secAckNum"}, secAckNum, sw);
    @(posedge clk); @(negedge clk);
    check("R7 single-cycle strobes", {priAck, secAck, vecValid}, 0);
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset outputs", {priAck, secAck, vecValid, cascadeReq}, 0);
        rstN = 1'b1;
        @(negedge clk);
        check("R10 idle no strobes", {priAck, secAck, vecValid}, 0);

        for (int b = 0; b < 4; b++) begin
          case (b)
            0: begin priBase = 8'h08; secBase = 8'h70; end
            1: begin priBase = 8'hFF; secBase = 8'h07; end
            2: begin priBase = 8'h25; secBase = 8'hAB; end
            default: begin priBase = 8'h00; secBase = 8'hF8; end
          endcase
          for (int c = 0; c < 256; c++)
            doAck(c[7], c[6:4], c[3], c[2:0]);
        end

        // R8: request held for two cycles, second is ignored
        secValid = 1'b0; priValid = 1'b1; priWin = 3'd5; ackReq = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R8 first accepted", vecValid, 1);
        @(posedge clk); @(negedge clk);
        ackReq = 1'b0;
        check("R8 back-to-back ignored", {priAck, secAck, vecValid}, 0);
        @(posedge clk); @(negedge clk);

        // R9: cascade pulse train
        secValid = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R9 low without secValid", cascadeReq, 0);
        secValid = 1'b1;
        for (int k = 0; k < 6; k++) begin
          @(posedge clk); @(negedge clk);
          check("R9 alternating", cascadeReq, (k % 2 == 0) ? 1 : 0);
        end
        secValid = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R9 stops after secValid low", cascadeReq, 0);
        check("R10 no strobes without request", {priAck, secAck, vecValid}, 0);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule